// File: doc/BRIEF.md
# Per-Pin Vector Timing Formatter

This block turns the vector stream for one tester pin into a timed waveform. Each vector carries a pin-state character, a time-set selector, a source data bit and an expected bit. A vector period is a whole number of ticks of a fast clock. Inside that period the block applies the edges of the selected time set: a drive-on edge, a data edge, a return edge, a drive-off edge and a single compare strobe. From these it produces a drive level, an output enable, a pass/fail verdict and a captured bit.

Time sets live in a small table. Each entry holds a period, the five edge ticks and a drive format. The table is written through a plain register port. A write that breaks a timing rule is refused, and the entry keeps its old contents. The block asks for the next vector with a one-cycle load strobe. The upstream source must hold the vector inputs valid in that cycle. The comparator inputs must be valid on the strobe tick.

Top module: `pin_fmt`

## Requirements
- R1: Drive states '0' (code 0), '1' (code 1) and D (code 7, which drives src_bit) set the level named by the state at the data edge. pin_oe rises after the drive-on tick and falls after the drive-off tick. Each edge shows on the outputs one tick after the tick on which it fires.
- R2: Format code 0 (non-return) leaves the level unchanged at drive-on and at return. Code 1 (return-to-low) drives 0 at drive-on and at return. Code 2 (return-to-high) drives 1 at both edges. Code 3 (surround-by-complement) drives the inverse of the data bit at both edges.
- R3: Non-drive states L (2), H (3), X (4), M (5), V (6) and E (8) hold pin_oe low from tick 0 of their vector. This holds even when the previous vector left the enable on.
- R4: At the strobe tick the block samples cmp_hi (pin above the high threshold) and cmp_lo (pin below the low threshold). cmp_done pulses one tick later. The verdict passes under these rules: L needs lo and not hi; H needs hi and not lo; M needs both clear; V needs exactly one set; E uses the H rule when exp_bit is 1 and the L rule when exp_bit is 0. X and the drive states give no cmp_done.
- R5: A passing V compare raises cap_valid together with cmp_done, and cap_bit then equals cmp_hi. A failing V compare leaves cap_valid low.
- R6: State code 9 ('-') reuses the resolved state of the previous vector. On the first vector after reset it acts as X, and rep_err pulses on tick 0 of that vector. Codes 10 to 15 act as X.
- R7: Time-set code 31 reuses the time set of the previous vector. On the first vector after reset it selects entry 0.
- R8: A table write is refused, with cfg_err pulsing in the next cycle, in any of these cases: the period is below MIN_PERIOD (4); drive-off is earlier than drive-on plus MIN_SEP (2); the format is code 3 with a period below 2*MIN_PERIOD; or the index is NUM_TS or more. A refused write leaves the entry unchanged.
- R9: Each vector lasts exactly the period of its time set in ticks. vec_load is high on the last tick. Edges at tick values at or beyond the period never fire. After reset every entry has period 16, format 0, drive-on 0, data 1 and strobe 8, with return and drive-off never firing.
- R10: After reset pin_oe, pin_drv, cmp_done and rep_err are 0, and vec_load is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Time-set table write strobe |
| cfg_idx | input | TS_W | Entry being written |
| cfg_period | input | TICK_W | Vector period in ticks |
| cfg_on | input | TICK_W | Drive-on tick |
| cfg_data | input | TICK_W | Data edge tick |
| cfg_ret | input | TICK_W | Return edge tick |
| cfg_off | input | TICK_W | Drive-off tick |
| cfg_strobe | input | TICK_W | Compare strobe tick |
| cfg_fmt | input | 2 | Drive format code |
| cfg_err | output | 1 | Write refused (one-cycle pulse) |
| vec_load | output | 1 | Vector inputs are taken at this clock edge |
| vec_state | input | 4 | Pin-state code |
| vec_tset | input | TS_W | Time-set selector, 31 = previous |
| src_bit | input | 1 | Source data for D |
| exp_bit | input | 1 | Expected data for E |
| cmp_hi | input | 1 | Pin above the high threshold |
| cmp_lo | input | 1 | Pin below the low threshold |
| pin_drv | output | 1 | Drive level |
| pin_oe | output | 1 | Driver enable |
| cmp_done | output | 1 | Compare result valid |
| cmp_fail | output | 1 | Compare failed |
| cap_valid | output | 1 | Captured bit valid |
| cap_bit | output | 1 | Captured bit |
| rep_err | output | 1 | Repeat state used with no previous vector |

## Verification
A wrong tick count or a bad latched period shows up on the first affected vector: the spacing of vec_load changes, and the strobe and edges land on the wrong tick. A wrong resolved state or time set shows at the ports within one period. It appears as a missing or extra cmp_done, a wrong verdict, or an enable and level that do not match the format. An edge action applied at the wrong tick, or with the wrong format level, is visible one tick after the edge when the level or enable is sampled at each tick of the period.

// File: rtl/pin_fmt_pkg.sv
package pin_fmt_pkg;

   typedef enum logic [3:0] {
      ST_DRV0   = 4'd0,
      ST_DRV1   = 4'd1,
      ST_CMPL   = 4'd2,
      ST_CMPH   = 4'd3,
      ST_MASK   = 4'd4,
      ST_MID    = 4'd5,
      ST_VALID  = 4'd6,
      ST_SRCD   = 4'd7,
      ST_SRCE   = 4'd8,
      ST_REPEAT = 4'd9
   } pin_state_e;

   typedef enum logic [1:0] {
      FMT_NR  = 2'd0,
      FMT_RL  = 2'd1,
      FMT_RH  = 2'd2,
      FMT_SBC = 2'd3
   } drv_fmt_e;

   function automatic logic is_drive_st(input pin_state_e s);
      return (s == ST_DRV0) || (s == ST_DRV1) || (s == ST_SRCD);
   endfunction

endpackage

// File: rtl/pin_fmt_tset.sv
module pin_fmt_tset
   import pin_fmt_pkg::*;
#(
   parameter int NUM_TS     = 31,
   parameter int TS_W       = 5,
   parameter int TICK_W     = 6,
   parameter int MIN_PERIOD = 4,
   parameter int MIN_SEP    = 2,
   parameter int DEF_PERIOD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [TS_W-1:0]   widx,
   input  logic [TICK_W-1:0] w_per,
   input  logic [TICK_W-1:0] w_on,
   input  logic [TICK_W-1:0] w_dat,
   input  logic [TICK_W-1:0] w_ret,
   input  logic [TICK_W-1:0] w_off,
   input  logic [TICK_W-1:0] w_stb,
   input  logic [1:0]        w_fmt,
   output logic              err,
   input  logic [TS_W-1:0]   ridx,
   output logic [TICK_W-1:0] r_per,
   output logic [TICK_W-1:0] r_on,
   output logic [TICK_W-1:0] r_dat,
   output logic [TICK_W-1:0] r_ret,
   output logic [TICK_W-1:0] r_off,
   output logic [TICK_W-1:0] r_stb,
   output drv_fmt_e          r_fmt
);

   localparam int EW     = TICK_W + 2;
   localparam int WORD_W = 6 * TICK_W + 2;
   localparam logic [EW-1:0]     MINP   = EW'(MIN_PERIOD);
   localparam logic [EW-1:0]     MINP2  = EW'(2 * MIN_PERIOD);
   localparam logic [EW-1:0]     SEP    = EW'(MIN_SEP);
   localparam logic [TS_W:0]     NTS    = (TS_W + 1)'(NUM_TS);
   localparam logic [TICK_W-1:0] NEVER  = '1;
   localparam logic [WORD_W-1:0] DEF_WORD = {FMT_NR, TICK_W'(DEF_PERIOD / 2), NEVER, NEVER,
                                             TICK_W'(1), TICK_W'(0), TICK_W'(DEF_PERIOD)};

   if (NUM_TS < 1 || NUM_TS >= (1 << TS_W)) begin : g_chk_ts
      $error("NUM_TS must leave one selector code free for repeat");
   end
   if (DEF_PERIOD < MIN_PERIOD || DEF_PERIOD >= (1 << TICK_W)) begin : g_chk_def
      $error("DEF_PERIOD out of range");
   end
   if (2 * MIN_PERIOD >= (1 << TICK_W)) begin : g_chk_min
      $error("MIN_PERIOD too large for TICK_W");
   end

   logic bad;
   always_comb begin
      bad = 1'b0;
      if ({2'b00, w_per} < MINP) bad = 1'b1;
      if ({2'b00, w_off} < ({2'b00, w_on} + SEP)) bad = 1'b1;
      if ((w_fmt == FMT_SBC) && ({2'b00, w_per} < MINP2)) bad = 1'b1;
      if ({1'b0, widx} >= NTS) bad = 1'b1;
   end

   logic [WORD_W-1:0] w_word;
   assign w_word = {w_fmt, w_stb, w_off, w_ret, w_dat, w_on, w_per};

   logic [WORD_W-1:0] ent [NUM_TS];

   for (genvar g = 0; g < NUM_TS; g++) begin : g_ent
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    word_q <= DEF_WORD;
         else if (we && !bad && (widx == TS_W'(g)))     word_q <= w_word;
      end
      assign ent[g] = word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= we && bad;
   end

   logic [WORD_W-1:0] r_word;
   always_comb begin
      if ({1'b0, ridx} < NTS) r_word = ent[ridx];
      else                    r_word = ent[0];
   end

   assign r_per = r_word[0*TICK_W +: TICK_W];
   assign r_on  = r_word[1*TICK_W +: TICK_W];
   assign r_dat = r_word[2*TICK_W +: TICK_W];
   assign r_ret = r_word[3*TICK_W +: TICK_W];
   assign r_off = r_word[4*TICK_W +: TICK_W];
   assign r_stb = r_word[5*TICK_W +: TICK_W];
   assign r_fmt = drv_fmt_e'(r_word[6*TICK_W +: 2]);

   // R8: a short complement-surround period is always refused
   p_sbc_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && w_fmt == FMT_SBC && {2'b00, w_per} < MINP2) |=> err);

endmodule

// File: rtl/pin_fmt_seq.sv
module pin_fmt_seq
   import pin_fmt_pkg::*;
#(
   parameter int TS_W       = 5,
   parameter int TICK_W     = 6,
   parameter int DEF_PERIOD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        vec_state,
   input  logic [TS_W-1:0]   vec_tset,
   input  logic              src_bit,
   input  logic              exp_bit,
   output logic [TS_W-1:0]   rd_idx,
   input  logic [TICK_W-1:0] rd_per,
   input  logic [TICK_W-1:0] rd_on,
   input  logic [TICK_W-1:0] rd_dat,
   input  logic [TICK_W-1:0] rd_ret,
   input  logic [TICK_W-1:0] rd_off,
   input  logic [TICK_W-1:0] rd_stb,
   input  drv_fmt_e          rd_fmt,
   output logic              load,
   output logic              nxt_drive,
   output logic              started,
   output logic [TICK_W-1:0] tick,
   output logic [TICK_W-1:0] c_on,
   output logic [TICK_W-1:0] c_dat,
   output logic [TICK_W-1:0] c_ret,
   output logic [TICK_W-1:0] c_off,
   output logic [TICK_W-1:0] c_stb,
   output drv_fmt_e          c_fmt,
   output pin_state_e        c_state,
   output logic              c_src,
   output logic              c_exp,
   output logic              rep_err
);

   localparam logic [TS_W-1:0] REP_TS  = '1;
   localparam logic [3:0]      REP_CODE = 4'(ST_REPEAT);

   logic [TICK_W-1:0] c_per;
   logic              have_prev;
   pin_state_e        prev_st;
   logic [TS_W-1:0]   prev_ts;
   pin_state_e        res_st;
   logic              rep_hit;

   always_comb begin
      rep_hit = 1'b0;
      if (vec_state <= 4'(ST_SRCE)) begin
         res_st = pin_state_e'(vec_state);
      end else if (vec_state == REP_CODE) begin
         if (have_prev) res_st = prev_st;
         else begin
            res_st  = ST_MASK;
            rep_hit = 1'b1;
         end
      end else begin
         res_st = ST_MASK;
      end
   end

   assign rd_idx    = (vec_tset == REP_TS) ? prev_ts : vec_tset;
   assign load      = !started || (tick == (c_per - TICK_W'(1)));
   assign nxt_drive = is_drive_st(res_st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started   <= 1'b0;
         tick      <= '0;
         c_per     <= TICK_W'(DEF_PERIOD);
         c_on      <= '1;
         c_dat     <= '1;
         c_ret     <= '1;
         c_off     <= '1;
         c_stb     <= '1;
         c_fmt     <= FMT_NR;
         c_state   <= ST_MASK;
         c_src     <= 1'b0;
         c_exp     <= 1'b0;
         have_prev <= 1'b0;
         prev_st   <= ST_MASK;
         prev_ts   <= '0;
         rep_err   <= 1'b0;
      end else begin
         rep_err <= load && rep_hit;
         if (load) begin
            started   <= 1'b1;
            tick      <= '0;
            c_per     <= rd_per;
            c_on      <= rd_on;
            c_dat     <= rd_dat;
            c_ret     <= rd_ret;
            c_off     <= rd_off;
            c_stb     <= rd_stb;
            c_fmt     <= rd_fmt;
            c_state   <= res_st;
            c_src     <= src_bit;
            c_exp     <= exp_bit;
            have_prev <= 1'b1;
            prev_st   <= res_st;
            prev_ts   <= rd_idx;
         end else begin
            tick <= tick + TICK_W'(1);
         end
      end
   end

   // R9: the tick counter never passes the latched period
   p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (tick < c_per));
   // R6: a repeat with no previous vector is reported
   p_first_rep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !have_prev && vec_state == REP_CODE) |=> rep_err);

endmodule

// File: rtl/pin_fmt_drive.sv
module pin_fmt_drive
   import pin_fmt_pkg::*;
#(
   parameter int TICK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] e_on,
   input  logic [TICK_W-1:0] e_dat,
   input  logic [TICK_W-1:0] e_ret,
   input  logic [TICK_W-1:0] e_off,
   input  drv_fmt_e          fmt,
   input  pin_state_e        state,
   input  logic              src,
   input  logic              load,
   input  logic              nxt_drive,
   output logic              pin_drv,
   output logic              pin_oe
);

   logic dbit, act, d_n, o_n;

   assign act  = is_drive_st(state);
   assign dbit = (state == ST_DRV1) || ((state == ST_SRCD) && src);

   function automatic logic frame_lvl(input drv_fmt_e f, input logic d, input logic cur);
      case (f)
         FMT_RL:  return 1'b0;
         FMT_RH:  return 1'b1;
         FMT_SBC: return ~d;
         default: return cur;
      endcase
   endfunction

   always_comb begin
      d_n = pin_drv;
      o_n = pin_oe;
      if (act) begin
         if (tick == e_on) begin
            o_n = 1'b1;
            d_n = frame_lvl(fmt, dbit, d_n);
         end
         if (tick == e_dat) d_n = dbit;
         if (tick == e_ret) d_n = frame_lvl(fmt, dbit, d_n);
         if (tick == e_off) o_n = 1'b0;
      end
      if (load && !nxt_drive) o_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_drv <= 1'b0;
         pin_oe  <= 1'b0;
      end else begin
         pin_drv <= d_n;
         pin_oe  <= o_n;
      end
   end

   // R1: the drive-off edge always releases the enable
   p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (act && tick == e_off) |=> !pin_oe);

endmodule

// File: rtl/pin_fmt_cmp.sv
module pin_fmt_cmp
   import pin_fmt_pkg::*;
#(
   parameter int TICK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              started,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] e_stb,
   input  pin_state_e        state,
   input  logic              exp_bit,
   input  logic              cmp_hi,
   input  logic              cmp_lo,
   output logic              cmp_done,
   output logic              cmp_fail,
   output logic              cap_valid,
   output logic              cap_bit
);

   logic hit, cmp_en, pass, is_low, is_high;

   assign hit     = started && (tick == e_stb);
   assign is_low  = cmp_lo && !cmp_hi;
   assign is_high = cmp_hi && !cmp_lo;

   always_comb begin
      cmp_en = 1'b1;
      pass   = 1'b0;
      case (state)
         ST_CMPL:  pass = is_low;
         ST_CMPH:  pass = is_high;
         ST_MID:   pass = !cmp_hi && !cmp_lo;
         ST_VALID: pass = cmp_hi ^ cmp_lo;
         ST_SRCE:  pass = exp_bit ? is_high : is_low;
         default:  cmp_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_done  <= 1'b0;
         cmp_fail  <= 1'b0;
         cap_valid <= 1'b0;
         cap_bit   <= 1'b0;
      end else begin
         cmp_done  <= hit && cmp_en;
         cmp_fail  <= hit && cmp_en && !pass;
         cap_valid <= hit && (state == ST_VALID) && pass;
         if (hit && state == ST_VALID) cap_bit <= cmp_hi;
      end
   end

   // R5: a capture is only reported with a compare result
   p_cap_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> (cmp_done && !cmp_fail));
   // R4: a failure is only reported with a compare result
   p_fail_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_fail |-> cmp_done);

endmodule

// File: rtl/pin_fmt.sv
module pin_fmt
   import pin_fmt_pkg::*;
#(
   parameter int NUM_TS     = 31,
   parameter int TS_W       = 5,
   parameter int TICK_W     = 6,
   parameter int MIN_PERIOD = 4,
   parameter int MIN_SEP    = 2,
   parameter int DEF_PERIOD = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [TS_W-1:0]   cfg_idx,
   input  logic [TICK_W-1:0] cfg_period,
   input  logic [TICK_W-1:0] cfg_on,
   input  logic [TICK_W-1:0] cfg_data,
   input  logic [TICK_W-1:0] cfg_ret,
   input  logic [TICK_W-1:0] cfg_off,
   input  logic [TICK_W-1:0] cfg_strobe,
   input  logic [1:0]        cfg_fmt,
   output logic              cfg_err,
   output logic              vec_load,
   input  logic [3:0]        vec_state,
   input  logic [TS_W-1:0]   vec_tset,
   input  logic              src_bit,
   input  logic              exp_bit,
   input  logic              cmp_hi,
   input  logic              cmp_lo,
   output logic              pin_drv,
   output logic              pin_oe,
   output logic              cmp_done,
   output logic              cmp_fail,
   output logic              cap_valid,
   output logic              cap_bit,
   output logic              rep_err
);

   logic [TS_W-1:0]   rd_idx;
   logic [TICK_W-1:0] rd_per, rd_on, rd_dat, rd_ret, rd_off, rd_stb;
   drv_fmt_e          rd_fmt;
   logic [TICK_W-1:0] tick, c_on, c_dat, c_ret, c_off, c_stb;
   drv_fmt_e          c_fmt;
   pin_state_e        c_state;
   logic              c_src, c_exp, started, nxt_drive;

   pin_fmt_tset #(
      .NUM_TS(NUM_TS), .TS_W(TS_W), .TICK_W(TICK_W),
      .MIN_PERIOD(MIN_PERIOD), .MIN_SEP(MIN_SEP), .DEF_PERIOD(DEF_PERIOD)
   ) u_tset (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we), .widx(cfg_idx), .w_per(cfg_period), .w_on(cfg_on),
      .w_dat(cfg_data), .w_ret(cfg_ret), .w_off(cfg_off), .w_stb(cfg_strobe),
      .w_fmt(cfg_fmt), .err(cfg_err),
      .ridx(rd_idx), .r_per(rd_per), .r_on(rd_on), .r_dat(rd_dat),
      .r_ret(rd_ret), .r_off(rd_off), .r_stb(rd_stb), .r_fmt(rd_fmt)
   );

   pin_fmt_seq #(
      .TS_W(TS_W), .TICK_W(TICK_W), .DEF_PERIOD(DEF_PERIOD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .vec_state(vec_state), .vec_tset(vec_tset), .src_bit(src_bit), .exp_bit(exp_bit),
      .rd_idx(rd_idx), .rd_per(rd_per), .rd_on(rd_on), .rd_dat(rd_dat),
      .rd_ret(rd_ret), .rd_off(rd_off), .rd_stb(rd_stb), .rd_fmt(rd_fmt),
      .load(vec_load), .nxt_drive(nxt_drive), .started(started), .tick(tick),
      .c_on(c_on), .c_dat(c_dat), .c_ret(c_ret), .c_off(c_off), .c_stb(c_stb),
      .c_fmt(c_fmt), .c_state(c_state), .c_src(c_src), .c_exp(c_exp),
      .rep_err(rep_err)
   );

   pin_fmt_drive #(.TICK_W(TICK_W)) u_drive (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .e_on(c_on), .e_dat(c_dat), .e_ret(c_ret), .e_off(c_off),
      .fmt(c_fmt), .state(c_state), .src(c_src),
      .load(vec_load), .nxt_drive(nxt_drive),
      .pin_drv(pin_drv), .pin_oe(pin_oe)
   );

   pin_fmt_cmp #(.TICK_W(TICK_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .started(started), .tick(tick),
      .e_stb(c_stb), .state(c_state), .exp_bit(c_exp),
      .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
      .cmp_done(cmp_done), .cmp_fail(cmp_fail),
      .cap_valid(cap_valid), .cap_bit(cap_bit)
   );

   // R3: loading a non-drive vector leaves the driver disabled from tick 0
   p_nondrive_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_load && !nxt_drive) |=> !pin_oe);

endmodule

// File: tb/pin_fmt_tb_top.sv
module pin_fmt_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TS_W   = 5;
   localparam int TICK_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [TS_W-1:0]   cfg_idx = '0;
   logic [TICK_W-1:0] cfg_period = '0, cfg_on = '0, cfg_data = '0;
   logic [TICK_W-1:0] cfg_ret = '0, cfg_off = '0, cfg_strobe = '0;
   logic [1:0]        cfg_fmt = '0;
   logic              cfg_err, vec_load;
   logic [3:0]        vec_state = 4'd9;
   logic [TS_W-1:0]   vec_tset = '1;
   logic              src_bit = 1'b0, exp_bit = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
   logic              pin_drv, pin_oe, cmp_done, cmp_fail, cap_valid, cap_bit, rep_err;

   int n_checks = 0;
   int n_errors = 0;

   logic drv_s [64];
   logic oe_s  [64];
   int   done_tk, per_n;
   logic fail_s, capv_s, capb_s, rep_s;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pin_fmt dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_period(cfg_period), .cfg_on(cfg_on),
      .cfg_data(cfg_data), .cfg_ret(cfg_ret), .cfg_off(cfg_off), .cfg_strobe(cfg_strobe),
      .cfg_fmt(cfg_fmt), .cfg_err(cfg_err), .vec_load(vec_load),
      .vec_state(vec_state), .vec_tset(vec_tset), .src_bit(src_bit), .exp_bit(exp_bit),
      .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .pin_drv(pin_drv), .pin_oe(pin_oe),
      .cmp_done(cmp_done), .cmp_fail(cmp_fail), .cap_valid(cap_valid),
      .cap_bit(cap_bit), .rep_err(rep_err)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic cfg_write(input int idx, input int per, input int on, input int dat,
                            input int ret, input int off, input int stb, input int fmt,
                            input logic exp_err, input string req);
      cfg_we     = 1'b1;
      cfg_idx    = TS_W'(idx);
      cfg_period = TICK_W'(per);
      cfg_on     = TICK_W'(on);
      cfg_data   = TICK_W'(dat);
      cfg_ret    = TICK_W'(ret);
      cfg_off    = TICK_W'(off);
      cfg_strobe = TICK_W'(stb);
      cfg_fmt    = 2'(fmt);
      @(negedge clk);
      cfg_we = 1'b0;
      chk_eq(req, int'(cfg_err), int'(exp_err));
   endtask

   // Presents one vector at the next load and records the whole period.
   task automatic run_vec(input int st, input int ts, input logic src, input logic ex,
                          input logic hi, input logic lo);
      while (!vec_load) @(negedge clk);
      vec_state = 4'(st);
      vec_tset  = TS_W'(ts);
      src_bit   = src;
      exp_bit   = ex;
      cmp_hi    = hi;
      cmp_lo    = lo;
      done_tk = -1; per_n = 0; rep_s = 1'b0;
      fail_s = 1'b0; capv_s = 1'b0; capb_s = 1'b0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         drv_s[i] = pin_drv;
         oe_s[i]  = pin_oe;
         if (rep_err) rep_s = 1'b1;
         if (cmp_done && done_tk < 0) begin
            done_tk = i;
            fail_s  = cmp_fail;
            capv_s  = cap_valid;
            capb_s  = cap_bit;
         end
         if (vec_load) begin
            per_n = i + 1;
            break;
         end
      end
   endtask

   task automatic t_reset();
      chk_eq("R10 pin_oe", int'(pin_oe), 0);
      chk_eq("R10 pin_drv", int'(pin_drv), 0);
      chk_eq("R10 cmp_done", int'(cmp_done), 0);
      chk_eq("R10 rep_err", int'(rep_err), 0);
      chk_eq("R10 vec_load", int'(vec_load), 1);
   endtask

   task automatic t_first_repeat();
      run_vec(9, 31, 1'b0, 1'b0, 1'b0, 1'b1);
      chk_eq("R6 rep_err on first repeat", int'(rep_s), 1);
      chk_eq("R6 first repeat acts as X, no compare", done_tk, -1);
      chk_eq("R6 first repeat no drive", int'(oe_s[5]), 0);
      chk_eq("R7 first tset repeat uses entry 0 period", per_n, 16);
   endtask

   task automatic t_config();
      cfg_write(1, 12, 1, 4, 8, 10, 6, 0, 1'b0, "R8 good NR write");
      cfg_write(2, 12, 1, 4, 8, 10, 6, 1, 1'b0, "R8 good RL write");
      cfg_write(3, 12, 1, 4, 8, 10, 6, 2, 1'b0, "R8 good RH write");
      cfg_write(4, 12, 1, 4, 8, 10, 6, 3, 1'b0, "R8 good SBC write");
      cfg_write(5, 6, 0, 1, 63, 63, 3, 0, 1'b0, "R8 good short write");
      cfg_write(7, 12, 1, 2, 63, 63, 6, 0, 1'b0, "R8 good hold write");
   endtask

   task automatic t_nr_drive();
      run_vec(1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R9 period of ts1", per_n, 12);
      chk_eq("R1 oe low before on edge", int'(oe_s[1]), 0);
      chk_eq("R1 oe high after on edge", int'(oe_s[2]), 1);
      chk_eq("R1 oe high up to off edge", int'(oe_s[10]), 1);
      chk_eq("R1 oe low after off edge", int'(oe_s[11]), 0);
      chk_eq("R2 NR holds previous level before data", int'(drv_s[3]), 0);
      chk_eq("R1 level after data edge", int'(drv_s[5]), 1);
      chk_eq("R2 NR no return", int'(drv_s[10]), 1);
      chk_eq("R1 drive state gives no compare", done_tk, -1);
   endtask

   task automatic t_formats();
      run_vec(1, 2, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R2 RL lead", int'(drv_s[3]), 0);
      chk_eq("R2 RL data", int'(drv_s[6]), 1);
      chk_eq("R2 RL return", int'(drv_s[10]), 0);
      run_vec(0, 3, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R2 RH lead", int'(drv_s[3]), 1);
      chk_eq("R2 RH data", int'(drv_s[6]), 0);
      chk_eq("R2 RH return", int'(drv_s[10]), 1);
      run_vec(7, 4, 1'b1, 1'b0, 1'b0, 1'b0);
      chk_eq("R2 SBC lead src1", int'(drv_s[3]), 0);
      chk_eq("R1 D drives src1", int'(drv_s[6]), 1);
      chk_eq("R2 SBC trail src1", int'(drv_s[10]), 0);
      run_vec(7, 4, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R2 SBC lead src0", int'(drv_s[3]), 1);
      chk_eq("R1 D drives src0", int'(drv_s[6]), 0);
      chk_eq("R2 SBC trail src0", int'(drv_s[10]), 1);
   endtask

   task automatic cmp_case(input int st, input logic ex, input logic hi, input logic lo,
                           input logic exp_fail, input string req);
      run_vec(st, 1, 1'b0, ex, hi, lo);
      chk_eq({req, " done tick"}, done_tk, 7);
      chk_eq({req, " verdict"}, int'(fail_s), int'(exp_fail));
   endtask

   task automatic t_compares();
      cmp_case(2, 1'b0, 1'b0, 1'b1, 1'b0, "R4 L low");
      cmp_case(2, 1'b0, 1'b1, 1'b0, 1'b1, "R4 L high");
      cmp_case(3, 1'b0, 1'b1, 1'b0, 1'b0, "R4 H high");
      cmp_case(3, 1'b0, 1'b0, 1'b0, 1'b1, "R4 H mid");
      cmp_case(5, 1'b0, 1'b0, 1'b0, 1'b0, "R4 M mid");
      cmp_case(5, 1'b0, 1'b1, 1'b0, 1'b1, "R4 M high");
      cmp_case(8, 1'b1, 1'b1, 1'b0, 1'b0, "R4 E exp1 high");
      cmp_case(8, 1'b0, 1'b1, 1'b0, 1'b1, "R4 E exp0 high");
      cmp_case(6, 1'b0, 1'b1, 1'b0, 1'b0, "R4 V high");
      chk_eq("R5 V capture valid high", int'(capv_s), 1);
      chk_eq("R5 V capture bit high", int'(capb_s), 1);
      cmp_case(6, 1'b0, 1'b0, 1'b1, 1'b0, "R4 V low");
      chk_eq("R5 V capture valid low", int'(capv_s), 1);
      chk_eq("R5 V capture bit low", int'(capb_s), 0);
      cmp_case(6, 1'b0, 1'b0, 1'b0, 1'b1, "R4 V mid");
      chk_eq("R5 no capture on failed V", int'(capv_s), 0);
      run_vec(4, 1, 1'b0, 1'b0, 1'b1, 1'b0);
      chk_eq("R4 X masked, no compare", done_tk, -1);
      run_vec(12, 1, 1'b0, 1'b0, 1'b1, 1'b0);
      chk_eq("R6 unused code acts as X", done_tk, -1);
   endtask

   task automatic t_oe_release();
      run_vec(1, 7, 1'b0, 1'b0, 1'b0, 1'b1);
      chk_eq("R9 off beyond period keeps oe", int'(oe_s[11]), 1);
      run_vec(2, 7, 1'b0, 1'b0, 1'b0, 1'b1);
      chk_eq("R3 non-drive clears oe at tick 0", int'(oe_s[0]), 0);
      chk_eq("R4 L pass after drive", int'(fail_s), 0);
   endtask

   task automatic t_repeat();
      run_vec(9, 31, 1'b0, 1'b0, 1'b0, 1'b1);
      chk_eq("R6 repeat L gives compare", done_tk, 7);
      chk_eq("R6 repeat L verdict", int'(fail_s), 0);
      chk_eq("R6 no rep_err after first vector", int'(rep_s), 0);
      chk_eq("R7 tset repeat keeps ts7 period", per_n, 12);
      run_vec(5, 5, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R9 short period", per_n, 6);
      chk_eq("R4 M strobe on short period", done_tk, 4);
      run_vec(5, 31, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R7 tset repeat keeps ts5 period", per_n, 6);
   endtask

   task automatic t_reject();
      cfg_write(6, 6, 0, 1, 2, 4, 3, 3, 1'b1, "R8 SBC short period refused");
      cfg_write(1, 12, 1, 4, 8, 2, 6, 0, 1'b1, "R8 off too close refused");
      cfg_write(2, 3, 0, 1, 2, 3, 1, 1, 1'b1, "R8 period below minimum refused");
      cfg_write(31, 12, 1, 4, 8, 10, 6, 0, 1'b1, "R8 index out of range refused");
      run_vec(1, 1, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R8 ts1 period kept", per_n, 12);
      chk_eq("R8 ts1 off edge kept", int'(oe_s[11]), 0);
      chk_eq("R8 ts1 on edge kept", int'(oe_s[2]), 1);
      run_vec(1, 2, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R8 ts2 still RL", int'(drv_s[10]), 0);
      run_vec(4, 6, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_eq("R8 ts6 keeps reset period", per_n, 16);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_repeat();
      t_config();
      t_nr_drive();
      t_formats();
      t_compares();
      t_oe_release();
      t_repeat();
      t_reject();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule